// File: doc/BRIEF.md
# PWM Trip Override Stage

This block sits between a two-channel PWM generator and the output pins. For each channel it either passes the raw PWM level through or overrides it when a fault event is present. An override can drive the pin high, drive it low, or release it to high impedance. It can also decline to act, which hands control to the next lower source. The fault sources are two digital-compare events per channel, called event 1 and event 2. Each event can take a synchronous path, registered once on the module clock, or an asynchronous path that goes straight through.

An event can feed either of two latches that are shared by both channels. The cycle-by-cycle latch releases at the next counter-zero strobe. The one-shot latch releases only when software clears it. Every source that feeds a latch uses the same shared action per channel. An event routed to neither latch uses its own action. That action follows the live event level, so the pin chops while the event toggles. Sticky flags record which kind of trip occurred. Software clears each flag by writing a one to it.

Top module: `pwm_trip_override`

## Requirements
- R1: After reset both latches and all flags are clear, every `pwm_oe` bit is 1, and `pwm_out` equals `pwm_in`.
- R2: A 2-bit action code means: 2'b00 high impedance (`pwm_oe`=0, `pwm_out`=0), 2'b01 drive high, 2'b10 drive low, 2'b11 no change. Every code other than 2'b00 leaves `pwm_oe`=1. For channel c the code sits in bits [2c+1:2c] of each action port. Channel 0 is output A and channel 1 is output B.
- R3: An event 2 whose `cbc_en2` bit is set forces the shared latched action in the same cycle. The force holds after the event falls. It stays through the cycle that carries `ctr_zero`, and the pin returns to PWM in the next cycle, unless the event is still high at that strobe.
- R4: An event whose `ost_en1` or `ost_en2` bit is set forces the shared latched action in the same cycle. The force survives `ctr_zero` and ends in the cycle after an `ost_clr` strobe.
- R5: Only event 2 can feed the cycle-by-cycle latch. Event 1 has no cycle-by-cycle enable, so if it is not one-shot routed it acts only through its direct action.
- R6: Both latches use one action per channel (`act_trip`), whichever event set them. An event routed to a latch has no effect through its own direct action code.
- R7: An unrouted event applies its own action while it is high. The pin returns to PWM in the same cycle the event falls, with no wait for a clock edge.
- R8: Each channel resolves its pin in this order: latched trip, then direct event 1, then direct event 2, then raw PWM. A code of 2'b11 passes control to the next source in that order.
- R9: With its `sync_evt` bit set, an event takes effect and releases exactly one clock edge later than on the asynchronous path.
- R10: `trip_flags` bit 0 records a cycle-by-cycle set and bit 1 a one-shot set. Bits 2+c record a direct event 1 on channel c and bits 4+c a direct event 2 on channel c. A flag sets at the clock edge after its cause and holds until a `flag_clr` bit clears it. When a set and a clear arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_in | input | 2 | Raw PWM levels, bit 0 = A, bit 1 = B |
| ctr_zero | input | 1 | Time-base counter-equals-zero strobe |
| dc_evt1 | input | 2 | Digital-compare event 1 per channel |
| dc_evt2 | input | 2 | Digital-compare event 2 per channel |
| sync_evt1 | input | 2 | 1 = event 1 registered, 0 = passed straight through |
| sync_evt2 | input | 2 | 1 = event 2 registered, 0 = passed straight through |
| ost_en1 | input | 2 | Route event 1 into the one-shot latch |
| ost_en2 | input | 2 | Route event 2 into the one-shot latch |
| cbc_en2 | input | 2 | Route event 2 into the cycle-by-cycle latch |
| act_trip | input | 4 | Shared latched action per channel |
| act_evt1 | input | 4 | Direct event 1 action per channel |
| act_evt2 | input | 4 | Direct event 2 action per channel |
| ost_clr | input | 1 | One-shot latch clear strobe |
| flag_clr | input | 6 | Write-one-to-clear for the flags |
| pwm_out | output | 2 | Overridden pin levels |
| pwm_oe | output | 2 | Pin drive enables, 0 = high impedance |
| trip_flags | output | 6 | Sticky trip flags |

## Verification
The clocked assertions assume the event, strobe and enable inputs are steady around each rising edge. An asynchronous event can still change the pins between edges, but the properties sample only at the edges. The bench changes every input at the falling edge and reads the pins shortly afterwards. This exercises the same-cycle asynchronous response and keeps every value the assertions see stable. The priority sweep clears the cycle-by-cycle latch with a quiet counter-zero cycle before each pattern. It also keeps every one-shot route off, so a latched state is present only when a pattern asks for it.

// File: rtl/trip_pkg.sv
// Shared action codes and the decode helper for the trip override stage.
// Assumes a 2-bit action code per source and per channel.
package trip_pkg;

    typedef enum logic [1:0] {
        ACT_HIZ  = 2'b00,
        ACT_HIGH = 2'b01,
        ACT_LOW  = 2'b10,
        ACT_KEEP = 2'b11
    } act_e;

    localparam int FLAG_CBC = 0;
    localparam int FLAG_OST = 1;

    // Decodes an action code into {drive enable, level}.
    function automatic logic [1:0] act_drive(input logic [1:0] code);
        unique case (code)
            ACT_HIZ:  act_drive = 2'b00;
            ACT_HIGH: act_drive = 2'b11;
            ACT_LOW:  act_drive = 2'b10;
            default:  act_drive = 2'b10;
        endcase
    endfunction

endpackage

// File: rtl/dc_evt_qual.sv
// Digital-compare event qualifier. Each event either passes straight
// through (asynchronous) or is registered once on the module clock.
// Assumes sync_sel is static while its event is active.
module dc_evt_qual #(
    parameter int N_EVT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] raw_i,
    input  logic [N_EVT-1:0] sync_sel_i,
    output logic [N_EVT-1:0] qual_o
);

    logic [N_EVT-1:0] evt_q;

    for (genvar i = 0; i < N_EVT; i++) begin : g_evt
        // Registers the event for the synchronous path.
        always_ff @(posedge clk) begin
            if (!rst_n) evt_q[i] <= 1'b0;
            else        evt_q[i] <= raw_i[i];
        end
        assign qual_o[i] = sync_sel_i[i] ? evt_q[i] : raw_i[i];

        AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
            sync_sel_i[i] && $stable(sync_sel_i[i]) |-> qual_o[i] == $past(raw_i[i])); // R9
    end

endmodule

// File: rtl/trip_latch.sv
// Set/clear trip latch. A set forces the active output in the same cycle.
// The held state then persists until a clear strobe arrives with no set.
// Assumes set and clear are synchronous to clk.
module trip_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic held_o,
    output logic active_o
);

    // Holds the trip; a set in the same cycle overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) held_o <= 1'b0;
        else        held_o <= set_i | (held_o & ~clr_i);
    end

    assign active_o = held_o | set_i;

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        held_o && !clr_i |=> held_o); // R3 R4
    AST_LATCH_SET:  assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> held_o); // R3 R4

endmodule

// File: rtl/pin_override.sv
// Per-channel pin resolver. The order is latched trip, then direct event 1,
// then direct event 2, then raw PWM. A "no change" code passes down a level.
// Purely combinational; clk and rst_n serve only the checks.
module pin_override
    import trip_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tripped_i,
    input  logic       dir1_i,
    input  logic       dir2_i,
    input  logic       pwm_i,
    input  logic [1:0] act_trip_i,
    input  logic [1:0] act_e1_i,
    input  logic [1:0] act_e2_i,
    output logic       pin_o,
    output logic       oe_o
);

    logic [1:0] drv;

    // Chooses the highest-priority source whose code is not "no change".
    always_comb begin
        if (tripped_i && act_trip_i != ACT_KEEP)  drv = act_drive(act_trip_i);
        else if (dir1_i && act_e1_i != ACT_KEEP)  drv = act_drive(act_e1_i);
        else if (dir2_i && act_e2_i != ACT_KEEP)  drv = act_drive(act_e2_i);
        else                                      drv = {1'b1, pwm_i};
    end

    assign oe_o  = drv[1];
    assign pin_o = drv[0];

    AST_HIZ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_o |-> !pin_o && ((tripped_i && act_trip_i == ACT_HIZ) ||
                   (dir1_i && act_e1_i == ACT_HIZ) ||
                   (dir2_i && act_e2_i == ACT_HIZ))); // R2
    AST_IDLE_PASS:  assert property (@(posedge clk) disable iff (!rst_n)
        !tripped_i && !dir1_i && !dir2_i |-> oe_o && pin_o == pwm_i); // R8

endmodule

// File: rtl/trip_flags.sv
// Sticky trip flags with write-one-to-clear. A set beats a same-cycle clear.
// Assumes set and clear bits are synchronous to clk.
module trip_flags #(
    parameter int N_FLAG = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_FLAG-1:0] set_i,
    input  logic [N_FLAG-1:0] clr_i,
    output logic [N_FLAG-1:0] flags_o
);

    // Updates each flag: set, else clear, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_o <= '0;
        else        flags_o <= set_i | (flags_o & ~clr_i);
    end

    for (genvar i = 0; i < N_FLAG; i++) begin : g_chk
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            flags_o[i] && !clr_i[i] |=> flags_o[i]); // R10
        AST_FLAG_CLEAR:  assert property (@(posedge clk) disable iff (!rst_n)
            clr_i[i] && !set_i[i] |=> !flags_o[i]); // R10
    end

endmodule

// File: rtl/pwm_trip_override.sv
// Trip override stage for a multi-channel PWM. Events are qualified,
// routed into the shared cycle-by-cycle and one-shot latches or the
// direct path, and then each pin is resolved. Assumes ctr_zero and ost_clr
// are single-cycle strobes on clk. Channel 0 is output A, channel 1 is output B.
module pwm_trip_override
    import trip_pkg::*;
#(
    parameter int N_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   pwm_in,
    input  logic              ctr_zero,
    input  logic [N_CH-1:0]   dc_evt1,
    input  logic [N_CH-1:0]   dc_evt2,
    input  logic [N_CH-1:0]   sync_evt1,
    input  logic [N_CH-1:0]   sync_evt2,
    input  logic [N_CH-1:0]   ost_en1,
    input  logic [N_CH-1:0]   ost_en2,
    input  logic [N_CH-1:0]   cbc_en2,
    input  logic [2*N_CH-1:0] act_trip,
    input  logic [2*N_CH-1:0] act_evt1,
    input  logic [2*N_CH-1:0] act_evt2,
    input  logic              ost_clr,
    input  logic [2*N_CH+1:0] flag_clr,
    output logic [N_CH-1:0]   pwm_out,
    output logic [N_CH-1:0]   pwm_oe,
    output logic [2*N_CH+1:0] trip_flags
);

    localparam int N_EVT  = 2 * N_CH;
    localparam int N_FLAG = 2 * N_CH + 2;

    logic [N_CH-1:0] q1, q2, dir1, dir2;
    logic            cbc_set, ost_set, cbc_held, ost_held, cbc_act, ost_act, tripped;

    dc_evt_qual #(.N_EVT(N_EVT)) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_i      ({dc_evt2, dc_evt1}),
        .sync_sel_i ({sync_evt2, sync_evt1}),
        .qual_o     ({q2, q1})
    );

    // Routes qualified events: only event 2 reaches the cycle-by-cycle latch.
    always_comb begin
        cbc_set = |(q2 & cbc_en2);
        ost_set = |(q1 & ost_en1) | |(q2 & ost_en2);
        dir1    = q1 & ~ost_en1;
        dir2    = q2 & ~ost_en2 & ~cbc_en2;
    end

    trip_latch u_cbc (
        .clk(clk), .rst_n(rst_n), .set_i(cbc_set), .clr_i(ctr_zero),
        .held_o(cbc_held), .active_o(cbc_act)
    );

    trip_latch u_ost (
        .clk(clk), .rst_n(rst_n), .set_i(ost_set), .clr_i(ost_clr),
        .held_o(ost_held), .active_o(ost_act)
    );

    assign tripped = ost_act | cbc_act;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        pin_override u_pin (
            .clk        (clk),
            .rst_n      (rst_n),
            .tripped_i  (tripped),
            .dir1_i     (dir1[c]),
            .dir2_i     (dir2[c]),
            .pwm_i      (pwm_in[c]),
            .act_trip_i (act_trip[2*c +: 2]),
            .act_e1_i   (act_evt1[2*c +: 2]),
            .act_e2_i   (act_evt2[2*c +: 2]),
            .pin_o      (pwm_out[c]),
            .oe_o       (pwm_oe[c])
        );
    end

    trip_flags #(.N_FLAG(N_FLAG)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   ({dir2, dir1, ost_set, cbc_set}),
        .clr_i   (flag_clr),
        .flags_o (trip_flags)
    );

    AST_CBC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        cbc_held && ctr_zero && !(|(q2 & cbc_en2)) |=> !cbc_held); // R3
    AST_OST_IGNORES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ost_held && ctr_zero && !ost_clr |=> ost_held); // R4
    AST_EVT1_NO_CBC: assert property (@(posedge clk) disable iff (!rst_n)
        !cbc_held && !(|(dc_evt2 | q2)) |=> !cbc_held); // R5

endmodule

// File: tb/pwm_trip_override_tb.sv
module pwm_trip_override_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] pwm_in, dc_evt1, dc_evt2, sync_evt1, sync_evt2;
    logic [1:0] ost_en1, ost_en2, cbc_en2, pwm_out, pwm_oe;
    logic [3:0] act_trip, act_evt1, act_evt2;
    logic       ctr_zero, ost_clr;
    logic [5:0] flag_clr, trip_flags;
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pwm_trip_override u_dut (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .ctr_zero(ctr_zero),
        .dc_evt1(dc_evt1), .dc_evt2(dc_evt2), .sync_evt1(sync_evt1),
        .sync_evt2(sync_evt2), .ost_en1(ost_en1), .ost_en2(ost_en2),
        .cbc_en2(cbc_en2), .act_trip(act_trip), .act_evt1(act_evt1),
        .act_evt2(act_evt2), .ost_clr(ost_clr), .flag_clr(flag_clr),
        .pwm_out(pwm_out), .pwm_oe(pwm_oe), .trip_flags(trip_flags)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Returns {oe, level} for one code: 00 hiZ, 01 high, 10 low.
    function automatic logic [1:0] code_pin(input logic [1:0] c);
        return (c == 2'd0) ? 2'b00 : (c == 2'd1) ? 2'b11 : 2'b10;
    endfunction

    // Priority model: latched, event 1, event 2, PWM; code 3 passes down.
    function automatic logic [1:0] exp_pin(input logic lat, e1, e2, pwm,
                                           input logic [1:0] ct, c1, c2);
        if (lat && ct != 2'd3) return code_pin(ct);
        if (e1 && c1 != 2'd3)  return code_pin(c1);
        if (e2 && c2 != 2'd3)  return code_pin(c2);
        return {1'b1, pwm};
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic look();
        #2;
    endtask

    task automatic quiet();
        dc_evt1 = '0; dc_evt2 = '0; sync_evt1 = '0; sync_evt2 = '0;
        ost_en1 = '0; ost_en2 = '0; cbc_en2 = '0; ctr_zero = 1'b0;
        ost_clr = 1'b0; flag_clr = '0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pwm_in = 2'b10; act_trip = '1; act_evt1 = '1; act_evt2 = '1;
        quiet();
        repeat (3) tick();
        rst_n = 1'b1;
        look();
        // R1 reset state
        chk("R1 out", {6'd0, pwm_out}, 8'h02);
        chk("R1 oe", {6'd0, pwm_oe}, 8'h03);
        chk("R1 flags", {2'd0, trip_flags}, 8'h00);

        // R3 cycle-by-cycle with opposite actions: A low, B high
        tick(); pwm_in = 2'b11; act_trip = 4'b01_10; cbc_en2 = 2'b01; dc_evt2 = 2'b01;
        look(); chk("R3 immediate", {4'd0, pwm_oe, pwm_out}, 8'h0E);
        tick(); dc_evt2 = 2'b00; pwm_in = 2'b01;
        look(); chk("R3 hold after event", {4'd0, pwm_oe, pwm_out}, 8'h0E);
        tick(); look(); chk("R3 hold later", {4'd0, pwm_oe, pwm_out}, 8'h0E);
        tick(); ctr_zero = 1'b1;
        look(); chk("R3 hold in zero cycle", {4'd0, pwm_oe, pwm_out}, 8'h0E);
        tick(); ctr_zero = 1'b0;
        look(); chk("R3 release after zero", {4'd0, pwm_oe, pwm_out}, 8'h0D);
        tick(); dc_evt2 = 2'b01; tick(); ctr_zero = 1'b1;
        tick(); ctr_zero = 1'b0; dc_evt2 = 2'b00;
        look(); chk("R3 event across zero keeps trip", {4'd0, pwm_oe, pwm_out}, 8'h0E);
        tick(); ctr_zero = 1'b1; tick(); ctr_zero = 1'b0;
        look(); chk("R3 later release", {4'd0, pwm_oe, pwm_out}, 8'h0D);

        // R5 event 1 cannot latch cycle-by-cycle; with no route it acts directly
        tick(); pwm_in = 2'b11; dc_evt1 = 2'b01; act_evt1 = 4'b11_10;
        look(); chk("R5 evt1 direct low", {6'd0, pwm_out}, 8'h02);
        tick(); dc_evt1 = 2'b00;
        look(); chk("R5 evt1 did not latch", {6'd0, pwm_out}, 8'h03);

        // R4 one-shot from event 1 on B: survives zero, ends after clear
        tick(); quiet(); ost_en1 = 2'b10; dc_evt1 = 2'b10; act_trip = 4'b10_00; act_evt1 = 4'b01_01;
        look(); chk("R4 set forces A hiZ, B low", {4'd0, pwm_oe, pwm_out}, 8'h08);
        tick(); dc_evt1 = 2'b00; ctr_zero = 1'b1;
        tick(); ctr_zero = 1'b0;
        look(); chk("R4 survives zero", {4'd0, pwm_oe, pwm_out}, 8'h08);
        tick(); ost_clr = 1'b1;
        look(); chk("R4 held in clear cycle", {4'd0, pwm_oe, pwm_out}, 8'h08);
        tick(); ost_clr = 1'b0;
        look(); chk("R4 released after clear", {4'd0, pwm_oe, pwm_out}, 8'h0F);

        // R6 routed events ignore their own direct code; shared "no change"
        tick(); quiet(); act_trip = 4'b11_11; act_evt2 = 4'b10_10; act_evt1 = 4'b10_10;
        cbc_en2 = 2'b01; ost_en1 = 2'b10; dc_evt2 = 2'b01; dc_evt1 = 2'b10;
        look(); chk("R6 routed direct code ignored", {4'd0, pwm_oe, pwm_out}, 8'h0F);
        tick(); act_trip = 4'b10_01;
        look(); chk("R6 shared pair from any source", {4'd0, pwm_oe, pwm_out}, 8'h0D);
        tick(); quiet(); ctr_zero = 1'b1; ost_clr = 1'b1; tick(); quiet();

        // R7 direct event chops the pin with the live level
        act_evt2 = 4'b11_10; act_evt1 = '1; act_trip = '1; pwm_in = 2'b11;
        for (int k = 0; k < 4; k++) begin
            dc_evt2 = 2'b01; look();
            chk("R7 forced while high", {6'd0, pwm_out}, 8'h02);
            #1; dc_evt2 = 2'b00; #1;
            chk("R7 released without a clock edge", {6'd0, pwm_out}, 8'h03);
            tick();
        end

        // R9 synchronous event path is one edge later
        sync_evt2 = 2'b01; dc_evt2 = 2'b01;
        look(); chk("R9 not yet applied", {6'd0, pwm_out}, 8'h03);
        tick(); dc_evt2 = 2'b00;
        look(); chk("R9 applied after edge", {6'd0, pwm_out}, 8'h02);
        tick(); look(); chk("R9 released after edge", {6'd0, pwm_out}, 8'h03);

        // R10 flags: clear all, direct event 2 on A sets bit 4, W1C, set wins
        tick(); quiet(); flag_clr = '1; tick(); flag_clr = '0;
        look(); chk("R10 cleared", {2'd0, trip_flags}, 8'h00);
        dc_evt2 = 2'b01; tick(); dc_evt2 = 2'b00;
        look(); chk("R10 direct A evt2 bit4", {2'd0, trip_flags}, 8'h10);
        flag_clr = 6'h01; tick(); flag_clr = '0;
        look(); chk("R10 other bit clear leaves flag", {2'd0, trip_flags}, 8'h10);
        dc_evt2 = 2'b01; flag_clr = 6'h10; tick(); dc_evt2 = 2'b00; flag_clr = '0;
        look(); chk("R10 set wins over clear", {2'd0, trip_flags}, 8'h10);
        flag_clr = 6'h10; tick(); flag_clr = '0;
        look(); chk("R10 W1C", {2'd0, trip_flags}, 8'h00);
        cbc_en2 = 2'b10; dc_evt2 = 2'b10; ost_en1 = 2'b01; dc_evt1 = 2'b01; tick(); quiet();
        look(); chk("R10 cbc bit0 and ost bit1", {2'd0, trip_flags}, 8'h03);
        ost_clr = 1'b1; ctr_zero = 1'b1; tick(); quiet();

        // R2 R8 sweep over codes and source states on channel A
        cbc_en2 = 2'b10; act_trip[3:2] = 2'b11; act_evt1[3:2] = 2'b11; act_evt2[3:2] = 2'b11;
        for (int ct = 0; ct < 4; ct++)
            for (int c1 = 0; c1 < 4; c1++)
                for (int c2 = 0; c2 < 4; c2++)
                    for (int s = 0; s < 16; s++) begin
                        tick(); dc_evt1 = '0; dc_evt2 = '0; ctr_zero = 1'b1;
                        tick(); ctr_zero = 1'b0;
                        act_trip[1:0] = 2'(ct); act_evt1[1:0] = 2'(c1); act_evt2[1:0] = 2'(c2);
                        pwm_in = {1'b0, s[3]};
                        dc_evt1 = {1'b0, s[1]};
                        dc_evt2 = {s[0], s[2]};
                        look();
                        chk("R2 R8 priority sweep", {6'd0, pwm_oe[0], pwm_out[0]},
                            {6'd0, exp_pin(s[0], s[1], s[2], s[3], 2'(ct), 2'(c1), 2'(c2))});
                    end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule